// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds the output latch of a general-purpose I/O port whose pins work in both directions without a direction register. When a bit of the latch holds 1, the pin is held high only by a weak pullup. External logic can overpower that pullup, so the same pin also serves as an input. When a bit holds 0, a strong pulldown drives the pin low. When a bit goes from 0 to 1, a strong pullup runs for a short, fixed number of clock cycles so that the pin rises quickly. After that, only the weak pullup holds the pin high.

A peripheral that shares a pin drives its own output bit. The block ANDs that bit with the latch bit, so either source can pull the pin low. For the peripheral to control the pin, its latch bit must stay at 1. The drive rules are the same whether the pin is used as plain I/O or by a peripheral. The CPU writes the whole latch in one cycle and can read back the stored latch value directly. It can also read the pin level, which passes through a two-stage synchronizer. The analog drivers themselves are outside this block.

Top module: `qbio_port_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every latch bit reads 1. With the peripheral output bits at 1, every weak pullup is on, and no strong pulldown or strong pullup is on.
- R2: A bit whose effective level is 1 and whose strong-pullup pulse has ended has only its weak pullup on. The effective level is the latch bit ANDed with the peripheral output bit.
- R3: A clock edge with the write strobe high loads the write data into the latch. A bit loaded with 0 turns on its strong pulldown and turns off both pullups. The pulldown stays on until a 1 is written to that bit or reset is asserted.
- R4: Writing 1 to a bit whose latch was 0 turns on its strong pullup for exactly BOOST_CYCLES clock cycles, counted from the write edge. After that pulse, only the weak pullup remains on. Default BOOST_CYCLES is 2.
- R5: Writing 1 to a bit whose latch already holds 1 produces no strong-pullup pulse.
- R6: When a peripheral output bit is 0, the strong pulldown of that bit is on even though its latch holds 1. When the peripheral output bit returns to 1, the same strong-pullup pulse as in R4 follows.
- R7: Bit i of the pin-read output equals bit i of the pin input as it was two clock edges earlier.
- R8: The latch-read output returns the stored latch bits from the cycle after the write edge onward.
- R9: A clock edge with the write strobe low leaves the latch, and therefore every drive enable, unchanged.
- R10: On any bit, the strong pulldown is never on at the same time as either pullup. A strong pullup is never on for a bit whose effective level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously by the chip's reset logic |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Value written to the latch |
| alt_out | input | WIDTH | Peripheral output bit per pin, ANDed with the latch |
| pin_in | input | WIDTH | Level sensed on each pin |
| weak_pu | output | WIDTH | Weak pullup enable per pin |
| strong_pd | output | WIDTH | Strong pulldown enable per pin |
| boost_pu | output | WIDTH | Momentary strong pullup enable per pin |
| latch_q | output | WIDTH | Stored latch bits |
| pin_q | output | WIDTH | Synchronized pin levels |

## Verification
A wrong latch bit shows up on the drive enables in the very next cycle. The pin is then either pulled down when it should be weakly high, or floating on a weak pullup when it should be driven low. A bad effective-level flop or pulse counter shows up as a strong-pullup pulse that is missing, too short or too long, or that fires on a 1-over-1 write. That error is visible within BOOST_CYCLES+1 cycles of the write or of the peripheral bit's rising edge. A fault in the synchronizer shows up as pin_q lagging pin_in by other than two edges, on the first edge where the pin changes.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  typedef enum logic [1:0] {
    DRV_PULL_LOW  = 2'd0,
    DRV_WEAK_HIGH = 2'd1,
    DRV_BOOST     = 2'd2
  } drv_e;
endpackage

// File: rtl/qbio_pin_sync.sv
module qbio_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] meta_q, meta_n;
  logic [WIDTH-1:0] stab_q, stab_n;

  always_comb begin
    meta_n = d_in;
    stab_n = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_n;
      stab_q <= stab_n;
    end
  end

  assign d_out = stab_q;
endmodule

// File: rtl/qbio_bit_drive.sv
module qbio_bit_drive
  import qbio_pkg::*;
#(
  parameter int BOOST_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic alt_bit,
  output logic latch_o,
  output logic weak_o,
  output logic pd_o,
  output logic boost_o
);
  localparam int CW = (BOOST_CYCLES < 2) ? 1 : $clog2(BOOST_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(BOOST_CYCLES - 1);

  logic          latch_q, latch_n;
  logic          eff_q, eff_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          eff, rise;
  drv_e          state;

  // effective level and its rising edge
  always_comb begin
    eff  = latch_q & alt_bit;
    rise = eff & ~eff_q;
  end

  // next state
  always_comb begin
    latch_n = latch_q;
    if (wr_en) latch_n = wr_bit;
    eff_n = eff;
    cnt_n = cnt_q;
    if (!eff)              cnt_n = '0;
    else if (rise)         cnt_n = RELOAD;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
      eff_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      latch_q <= latch_n;
      eff_q   <= eff_n;
      cnt_q   <= cnt_n;
    end
  end

  // drive decode
  always_comb begin
    if (!eff)                         state = DRV_PULL_LOW;
    else if (rise || cnt_q != '0)     state = DRV_BOOST;
    else                              state = DRV_WEAK_HIGH;
  end

  assign latch_o = latch_q;
  assign pd_o    = (state == DRV_PULL_LOW);
  assign boost_o = (state == DRV_BOOST);
  assign weak_o  = (state != DRV_PULL_LOW);
endmodule

// File: rtl/qbio_port_ctrl.sv
module qbio_port_ctrl #(
  parameter int WIDTH        = 8,
  parameter int BOOST_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] weak_pu,
  output logic [WIDTH-1:0] strong_pd,
  output logic [WIDTH-1:0] boost_pu,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] pin_q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    qbio_bit_drive #(.BOOST_CYCLES(BOOST_CYCLES)) u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bit  (wr_data[g]),
      .alt_bit (alt_out[g]),
      .latch_o (latch_q[g]),
      .weak_o  (weak_pu[g]),
      .pd_o    (strong_pd[g]),
      .boost_o (boost_pu[g])
    );
  end

  qbio_pin_sync #(.WIDTH(WIDTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .d_out (pin_q)
  );
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int WIDTH        = 8,
  parameter int BOOST_CYCLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] alt_out,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] weak_pu,
  input logic [WIDTH-1:0] strong_pd,
  input logic [WIDTH-1:0] boost_pu,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] pin_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_pd & (weak_pu | boost_pu)) == '0);

  assert_boost_eff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_pu & ~(latch_q & alt_out)) == '0);

  assert_one_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (weak_pu | strong_pd) == '1);

  assert_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && wr_en) |=> latch_q == $past(wr_data));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !wr_en) |=> $stable(latch_q));

  assert_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> pin_q == $past(pin_in, 2));
endmodule

bind qbio_port_ctrl qbio_port_chk #(.WIDTH(WIDTH), .BOOST_CYCLES(BOOST_CYCLES)) u_chk (.*);

// File: tb/sim_qbio_port_ctrl.sv
module sim_qbio_port_ctrl;
  localparam int W  = 8;
  localparam int BC = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [W-1:0] wr_data, alt_out, pin_in;
  logic [W-1:0] weak_pu, strong_pd, boost_pu, latch_q, pin_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  qbio_port_ctrl #(.WIDTH(W), .BOOST_CYCLES(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .alt_out(alt_out), .pin_in(pin_in), .weak_pu(weak_pu),
    .strong_pd(strong_pd), .boost_pu(boost_pu), .latch_q(latch_q),
    .pin_q(pin_q)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_out(input logic [W-1:0] lat, input logic [W-1:0] alt,
                           input string req);
    logic [W-1:0] e;
    e = lat & alt;
    check(latch_q == lat, {req, " latch"}, latch_q, lat);
    check(strong_pd == ~e, {req, " pulldown"}, strong_pd, ~e);
    check(weak_pu == e, {req, " weak"}, weak_pu, e);
  endtask

  task automatic write(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    drive_out('1, '1, "R1");
    check(boost_pu == '0, "R1 boost", boost_pu, '0);
  endtask

  task automatic t_write_zero;
    write(8'hA5);
    drive_out(8'hA5, '1, "R3");
    check(boost_pu == '0, "R3 boost", boost_pu, '0);
    repeat (5) @(negedge clk);
    check(strong_pd == 8'h5A, "R3 held", strong_pd, 8'h5A);
  endtask

  task automatic t_boost;
    // latch A5 -> FF: bits 0x5A rise
    write(8'hFF);
    for (int k = 0; k < BC; k++) begin
      check(boost_pu == 8'h5A, "R4 pulse", boost_pu, 8'h5A);
      if (k < BC - 1) @(negedge clk);
    end
    @(negedge clk);
    check(boost_pu == '0, "R4 end", boost_pu, '0);
    drive_out('1, '1, "R2");
  endtask

  task automatic t_one_over_one;
    write(8'hFF);
    check(boost_pu == '0, "R5 no pulse", boost_pu, '0);
    @(negedge clk);
    check(boost_pu == '0, "R5 no pulse later", boost_pu, '0);
  endtask

  task automatic t_no_write;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    @(negedge clk);
    drive_out('1, '1, "R9");
    check(boost_pu == '0, "R9 boost", boost_pu, '0);
  endtask

  task automatic t_latch_read;
    write(8'h3C);
    check(latch_q == 8'h3C, "R8 read", latch_q, 8'h3C);
    write(8'hFF);
    repeat (BC + 1) @(negedge clk);
  endtask

  task automatic t_alt;
    @(negedge clk); alt_out = 8'hF0;
    #1;
    check(strong_pd == 8'h0F, "R6 alt low", strong_pd, 8'h0F);
    check(latch_q == 8'hFF, "R6 latch kept", latch_q, 8'hFF);
    @(negedge clk); alt_out = '1;
    #1;
    check(boost_pu == 8'h0F, "R6 alt rise pulse", boost_pu, 8'h0F);
    repeat (BC) @(negedge clk);
    check(boost_pu == '0, "R6 pulse end", boost_pu, '0);
  endtask

  task automatic t_sync;
    @(negedge clk); pin_in = 8'h96;
    @(negedge clk);
    check(pin_q != 8'h96, "R7 not after one edge", pin_q, 8'h96);
    @(negedge clk);
    check(pin_q == 8'h96, "R7 after two edges", pin_q, 8'h96);
    pin_in = 8'h21;
    repeat (2) @(negedge clk);
    check(pin_q == 8'h21, "R7 second value", pin_q, 8'h21);
  endtask

  task automatic t_reset_mid;
    write(8'h00);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(latch_q == '1, "R1 async reset", latch_q, '1);
    check(strong_pd == '0, "R1 reset pulldown", strong_pd, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; alt_out = '1; pin_in = '0;
    repeat (3) @(negedge clk);
    check(latch_q == '1, "R1 during reset", latch_q, '1);
    rst_n = 1'b1;
    t_reset();
    t_write_zero();
    t_boost();
    t_one_over_one();
    t_no_write();
    t_latch_read();
    t_alt();
    t_sync();
    t_reset_mid();
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule